// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the control port of a line transceiver. A host reaches it through a four-wire synchronous serial link: a serial clock, an active-low select, a data input and a data output. Each access moves one byte in each direction at once. The byte shifted in becomes the new control word. The byte shifted out is a status word that holds the link flags.

The block also keeps an active-low interrupt. The interrupt is latched whenever the loop-sync flag or the line-signal flag changes. It also keeps a sticky flag that records line-code violations. The serial pins are oversampled on the chip clock `clk`, so every internal decision is made on that clock. Each serial edge takes effect one `clk` cycle after it is seen. Because every access also writes the control word, a host that only wants to read must send the current control word back.

Top module: `serctl_port`

## Requirements
- R1: After reset the control word is 0x00, `irq_n` is 1 and `ser_dout_en` is 0. The stored copy of the two link flags also resets to 0.
- R2: `ser_dout_en` is 0 while `ser_sel_n` is high. It becomes 1 one `clk` cycle after `ser_sel_n` falls, and at that point `ser_dout` already carries status bit 7.
- R3: `ser_din` is sampled on rising `ser_clk` edges, most significant bit first. `ser_dout` moves to the next lower status bit on each falling `ser_clk` edge.
- R4: The control word takes the eight received bits at the eighth rising edge of an access. An access with fewer than eight rising edges leaves the control word unchanged. Rising edges after the eighth are ignored.
- R5: The status byte is laid out as follows: bits 7..3 echo control bits 7..3, bit 2 is the violation flag, bit 1 is `sync_ok` and bit 0 is `sig_present`.
- R6: The status byte is captured when `ser_sel_n` falls. Flag changes during the access do not alter the bits being shifted out.
- R7: `irq_n` goes low one `clk` cycle after `sync_ok` or `sig_present` changes, and it stays low until it is released.
- R8: `irq_n` is released by the first rising `ser_clk` edge of an access. A flag change in that same cycle keeps it low, and a change later in the access latches it again.
- R9: A one-cycle `viol_pulse` sets the violation flag. The flag stays set without touching `irq_n` and is cleared when `ser_sel_n` returns high.
- R10: Every complete access writes the control word, including one intended as a read. Sending the previous word back leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_sel_n | input | 1 | Active-low access select |
| ser_din | input | 1 | Serial control data in |
| sync_ok | input | 1 | Loop-in-sync flag |
| sig_present | input | 1 | Line-signal-present flag |
| viol_pulse | input | 1 | One-cycle line-code violation event |
| ser_dout | output | 1 | Serial status data out |
| ser_dout_en | output | 1 | Output enable for `ser_dout` (tri-state control) |
| irq_n | output | 1 | Latched active-low interrupt |
| ctrl_word | output | 8 | Current control word |

## Verification
A wrong bit counter shows up at the end of the very access in which it goes wrong. The control word then loads early, late or on an aborted access, and because bits 7..3 are echoed back, the next read shows the error too. A stuck or mis-timed snapshot or shift register corrupts the status byte returned by the current access, so every read exposes it. A wrong interrupt or violation latch shows up either at `irq_n` within a cycle of the flag event or in bit 2 of the following read.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int unsigned CTRL_W  = 8;
    localparam int unsigned FLAG_W  = 2;

    typedef struct packed {
        logic sclk;
        logic sel_n;
    } edge_st_t;

    typedef struct packed {
        logic [FLAG_W-1:0] prev;
        logic              irq;
        logic              viol;
    } stat_st_t;
endpackage

// File: rtl/sctl_edge.sv
module sctl_edge
    import sctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_sel_n,
    output logic clk_rise,
    output logic clk_fall,
    output logic sel_fall,
    output logic sel_rise,
    output logic active
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d.sclk  = ser_clk;
        st_d.sel_n = ser_sel_n;
        clk_rise   = ser_clk & ~st_q.sclk;
        clk_fall   = ~ser_clk & st_q.sclk;
        sel_fall   = ~ser_sel_n & st_q.sel_n;
        sel_rise   = ser_sel_n & ~st_q.sel_n;
        active     = ~ser_sel_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk  <= 1'b0;
            st_q.sel_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sctl_stat.sv
module sctl_stat
    import sctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_ok,
    input  logic sig_present,
    input  logic viol_pulse,
    input  logic clr_irq,
    input  logic clr_viol,
    output logic irq,
    output logic viol
);
    stat_st_t st_d, st_q;
    logic [FLAG_W-1:0] cur;
    logic              changed;

    always_comb begin
        cur     = {sync_ok, sig_present};
        changed = (cur != st_q.prev);
        st_d      = st_q;
        st_d.prev = cur;
        // a new change outranks the release
        if (changed)      st_d.irq = 1'b1;
        else if (clr_irq) st_d.irq = 1'b0;
        if (viol_pulse)    st_d.viol = 1'b1;
        else if (clr_viol) st_d.viol = 1'b0;
        irq  = st_q.irq;
        viol = st_q.viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             clk_rise,
    input  logic             clk_fall,
    input  logic             sel_fall,
    input  logic             sel_rise,
    input  logic             din,
    input  logic [WIDTH-1:0] status,
    output logic             dout,
    output logic             dout_en,
    output logic [WIDTH-1:0] ctrl,
    output logic             first_rise
);
    localparam int unsigned CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] FULL = CW'(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic [WIDTH-1:0] tx;
        logic [WIDTH-1:0] rx;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] ctrl;
        logic             dout;
        logic             oe;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [WIDTH-1:0] rx_next;

    always_comb begin
        st_d       = st_q;
        rx_next    = {st_q.rx[WIDTH-2:0], din};
        first_rise = active & clk_rise & (st_q.cnt == '0);
        if (sel_fall) begin
            st_d.tx   = status;
            st_d.dout = status[WIDTH-1];
            st_d.rx   = '0;
            st_d.cnt  = '0;
            st_d.oe   = 1'b1;
        end else if (active) begin
            if (clk_rise && st_q.cnt != FULL) begin
                st_d.rx  = rx_next;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) st_d.ctrl = rx_next;
            end
            if (clk_fall) begin
                st_d.tx   = {st_q.tx[WIDTH-2:0], 1'b0};
                st_d.dout = st_q.tx[WIDTH-2];
            end
        end
        if (sel_rise) st_d.oe = 1'b0;
        dout    = st_q.dout;
        dout_en = st_q.oe;
        ctrl    = st_q.ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/serctl_port.sv
module serctl_port
    import sctl_pkg::*;
#(
    parameter int unsigned WIDTH = CTRL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_sel_n,
    input  logic             ser_din,
    input  logic             sync_ok,
    input  logic             sig_present,
    input  logic             viol_pulse,
    output logic             ser_dout,
    output logic             ser_dout_en,
    output logic             irq_n,
    output logic [WIDTH-1:0] ctrl_word
);
    localparam int unsigned ECHO_LO = FLAG_W + 1;

    logic clk_rise, clk_fall, sel_fall, sel_rise, active;
    logic first_rise, irq, viol;
    logic [WIDTH-1:0] status;
    logic [WIDTH-1:0] ctrl_q;

    sctl_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .clk_rise(clk_rise), .clk_fall(clk_fall), .sel_fall(sel_fall),
        .sel_rise(sel_rise), .active(active)
    );

    sctl_stat u_stat (
        .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .sig_present(sig_present),
        .viol_pulse(viol_pulse), .clr_irq(first_rise), .clr_viol(sel_rise),
        .irq(irq), .viol(viol)
    );

    always_comb begin
        status = {ctrl_q[WIDTH-1:ECHO_LO], viol, sync_ok, sig_present};
    end

    sctl_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .clk_rise(clk_rise),
        .clk_fall(clk_fall), .sel_fall(sel_fall), .sel_rise(sel_rise),
        .din(ser_din), .status(status), .dout(ser_dout), .dout_en(ser_dout_en),
        .ctrl(ctrl_q), .first_rise(first_rise)
    );

    assign ctrl_word = ctrl_q;
    assign irq_n     = ~irq;
endmodule

// File: rtl/serctl_port_chk.sv
module serctl_port_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_clk,
    input logic             ser_sel_n,
    input logic             sync_ok,
    input logic             sig_present,
    input logic             ser_dout_en,
    input logic             irq_n,
    input logic [WIDTH-1:0] ctrl_word
);
    // R4
    ctrl_load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> $past(ser_clk && !ser_sel_n));
    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sel_n && $past(ser_sel_n)) |-> !ser_dout_en);
    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_sel_n) |=> ser_dout_en);
    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> (($past(sync_ok) != $past(sync_ok, 2)) ||
                          ($past(sig_present) != $past(sig_present, 2))));
    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(ser_clk && !ser_sel_n));
endmodule

bind serctl_port serctl_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .sync_ok(sync_ok), .sig_present(sig_present), .ser_dout_en(ser_dout_en),
    .irq_n(irq_n), .ctrl_word(ctrl_word)
);

// File: tb/serctl_port_tb_top.sv
module serctl_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
    logic sync_ok = 1'b0, sig_present = 1'b0, viol_pulse = 1'b0;
    logic ser_dout, ser_dout_en, irq_n;
    logic [7:0] ctrl_word;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] ctrl_exp = 8'h00;
    bit irq_exp = 1'b0, viol_exp = 1'b0;

    always #5 clk = ~clk;

    serctl_port dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .sync_ok(sync_ok), .sig_present(sig_present),
        .viol_pulse(viol_pulse), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
        .irq_n(irq_n), .ctrl_word(ctrl_word)
    );

    function automatic logic [7:0] status_exp();
        return {ctrl_exp[7:3], viol_exp, sync_ok, sig_present};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_flags(input logic s, input logic g);
        @(negedge clk);
        if (s != sync_ok || g != sig_present) irq_exp = 1'b1;
        sync_ok = s;
        sig_present = g;
        repeat (3) @(negedge clk);
        chk(irq_n == !irq_exp, "R7", "irq_n after flag update", irq_n, !irq_exp);
    endtask

    task automatic pulse_viol();
        @(negedge clk) viol_pulse = 1'b1;
        @(negedge clk) viol_pulse = 1'b0;
        viol_exp = 1'b1;
        repeat (2) @(negedge clk);
        chk(irq_n == !irq_exp, "R9", "violation leaves irq_n", irq_n, !irq_exp);
    endtask

    // one access: nbits rising edges, optional sync_ok toggle at bit flip_at
    task automatic xfer(input logic [7:0] wr, input int nbits, input int flip_at,
                        input string req);
        logic [7:0] rd = 8'h00;
        logic [7:0] exp_rd;
        exp_rd = status_exp();
        @(negedge clk) ser_sel_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(ser_dout_en == 1'b1, "R2", "enable after select", ser_dout_en, 1);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (i < 8) rd[7-i] = ser_dout;
            ser_din = (i < 8) ? wr[7-i] : 1'b0;
            ser_clk = 1'b1;
            if (i == flip_at) sync_ok = ~sync_ok;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        ser_sel_n = 1'b1;
        repeat (3) @(negedge clk);
        if (nbits >= 1) irq_exp = 1'b0;
        if (flip_at >= 1 && flip_at < nbits) irq_exp = 1'b1;
        if (nbits >= 8) begin
            ctrl_exp = wr;
            chk(rd == exp_rd, req, "status byte read", rd, exp_rd);
        end
        viol_exp = 1'b0;
        chk(ctrl_word == ctrl_exp, req, "control word", ctrl_word, ctrl_exp);
        chk(irq_n == !irq_exp, "R8", "irq_n after access", irq_n, !irq_exp);
        chk(ser_dout_en == 1'b0, "R2", "enable after deselect", ser_dout_en, 0);
    endtask

    initial begin
        void'($urandom(32'h1d2c_3b4a));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(ctrl_word == 8'h00, "R1", "reset control", ctrl_word, 0);
        chk(irq_n == 1'b1, "R1", "reset irq_n", irq_n, 1);
        chk(ser_dout_en == 1'b0, "R1", "reset enable", ser_dout_en, 0);
        // R3 R5 full write and status read
        xfer(8'hA5, 8, -1, "R3");
        xfer(8'h5A, 8, -1, "R5");
        // R4 aborted access after 3 bits
        xfer(8'hFF, 3, -1, "R4");
        // R4 extra edges beyond eight ignored
        xfer(8'hC3, 9, -1, "R4");
        // R10 read repeating word keeps mode
        xfer(ctrl_word, 8, -1, "R10");
        // R7 change, R8 release
        set_flags(1'b1, 1'b0);
        set_flags(1'b1, 1'b1);
        xfer(8'h18, 8, -1, "R8");
        // R9 sticky violation, cleared after read
        pulse_viol();
        xfer(8'h18, 8, -1, "R9");
        xfer(8'h18, 8, -1, "R9");
        // R6 snapshot while flag flips mid-access; R8 re-latch
        xfer(8'hE7, 8, 3, "R6");
        // random mix
        for (int n = 0; n < 40; n++) begin
            if ($urandom_range(0, 2) == 0)
                set_flags(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) pulse_viol();
            xfer(8'($urandom), ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 7)) : 8,
                 -1, "R4");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule